// File: doc/BRIEF.md
# Word-Fed Transmit Frame Assembler

This block sits between a processor-facing data register and an Ethernet transmit path. Software feeds one outgoing frame as a series of 32-bit words. The first word of a frame, called the length word, holds the payload length in its low half-word and the first two frame bytes in its upper half. Each later word adds four more bytes. The block adds the 14-byte header to the payload length to get the number of bytes to collect. When software supplies the CRC itself, 4 more bytes are added to that count. The block stores the bytes in a local buffer until the count is reached.

Once a frame is complete, the block drops the software CRC bytes from the sent length when CRC insertion is off. It can optionally pad a short frame with zeros up to 60 bytes. It then streams the frame out one byte per handshake, marking the first and last bytes. When the last byte is accepted it reports completion, and it expects a new length word. An oversize length is refused with an error pulse, and no frame is started. A rearm strobe drops a partly collected frame.

Both data paths use valid/ready. An input word is taken on a clock edge where `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` is low for the whole time a frame is streaming out. An output byte moves on an edge where `out_valid_o` and `out_ready_i` are both high. While `out_ready_i` is low, the block holds its output valid and keeps the data and markers unchanged.

Top module: `txw_framer`

## Requirements
- R1: After reset the block accepts words (`wr_ready_o`=1), shows no output byte, and `done_o` and `err_o` are 0.
- R2: A word accepted while expecting a length word whose bits 15:0 exceed 2032 raises `err_o` for one cycle after the accepting edge, and starts no frame: the next word is again taken as a length word.
- R3: For a valid length L, the collect target is L+14 bytes when `crc_ins_i`=1, and L+18 bytes when `crc_ins_i`=0. `crc_ins_i` is sampled with the length word.
- R4: Frame byte 0 is length-word bits 23:16 and byte 1 is bits 31:24. Each later word supplies the next four bytes, bits 7:0 first.
- R5: The frame is complete on the word that brings the collected count to the target or past it. The sent data length equals the target when CRC insertion is on, and the target minus 4 when it is off. Bytes collected beyond that length are never sent.
- R6: If `pad_en_i` is 1 at completion and the sent data length is below 60, zero bytes follow the data until 60 bytes have been sent. A frame of exactly 60 bytes, or any frame when `pad_en_i` is 0, is sent unpadded.
- R7: `out_sop_o` marks the first byte of a frame and `out_eop_o` marks the last. While `out_valid_o`=1 and `out_ready_i`=0, the next cycle keeps `out_valid_o`=1 with unchanged `out_data_o`.
- R8: `wr_ready_o` is 0 whenever `out_valid_o` is 1.
- R9: `done_o` pulses for one cycle after the edge that accepts the last byte. The block then takes the next word as a length word.
- R10: A `rearm_i` pulse while a frame is being collected discards it. The next word is taken as a length word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_ins_i | input | 1 | 1: CRC appended downstream; 0: software supplies 4 CRC bytes |
| pad_en_i | input | 1 | Pad short frames with zeros to 60 bytes |
| rearm_i | input | 1 | Abandon the frame being collected |
| wr_valid_i | input | 1 | Input word valid |
| wr_ready_o | output | 1 | Input word can be taken |
| wr_data_i | input | 32 | Input word |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream takes the byte |
| out_data_o | output | 8 | Output byte |
| out_sop_o | output | 1 | First byte of frame |
| out_eop_o | output | 1 | Last byte of frame |
| done_o | output | 1 | One-cycle frame-sent pulse |
| err_o | output | 1 | One-cycle oversize-length pulse |

## Verification
The timing of each result is fixed. `err_o` is due in the cycle right after the edge that takes an oversize length word. The first output byte is valid in the cycle after the edge that takes the completing word. Each later byte follows one cycle after a handshake. `done_o` is due one cycle after the edge that takes the last byte. The bench drives and samples on the falling edge. It decides `out_ready_i` before it evaluates the handshake, so each pop from the scoreboard matches the byte consumed at the next rising edge. It checks `err_o` and `done_o` at the first falling edge after their causing edge. Irregular ready patterns test stalls, and filler beyond the data length tests that surplus bytes never leave.

// File: rtl/txw_pkg.sv
package txw_pkg;
  typedef enum logic [1:0] {
    ST_LEN  = 2'd0,
    ST_FILL = 2'd1,
    ST_SEND = 2'd2
  } txw_state_e;

  localparam int unsigned HDR_BYTES = 14;
  localparam int unsigned CRC_BYTES = 4;
endpackage

// File: rtl/txw_len_calc.sv
module txw_len_calc #(
  parameter int unsigned MAX_LEN = 2032,
  parameter int unsigned CW      = 13
) (
  input  logic [15:0]   len_i,
  input  logic          crc_ins_i,
  output logic          too_long_o,
  output logic [CW-1:0] target_o
);
  import txw_pkg::*;

  logic [CW-1:0] extra;

  always_comb begin
    too_long_o = (32'(len_i) > MAX_LEN);
    extra      = crc_ins_i ? CW'(HDR_BYTES) : CW'(HDR_BYTES + CRC_BYTES);
    target_o   = CW'(len_i) + extra;
  end
endmodule

// File: rtl/txw_buf.sv
module txw_buf #(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned AW        = 11,
  parameter int unsigned CW        = 13
) (
  input  logic          clk,
  input  logic          wr_first_i,
  input  logic          wr_word_i,
  input  logic [CW-1:0] wr_ptr_i,
  input  logic [31:0]   wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (wr_first_i) begin
      mem[0] <= wr_data_i[23:16];
      mem[1] <= wr_data_i[31:24];
    end else if (wr_word_i) begin
      for (int k = 0; k < 4; k++) begin
        if ((wr_ptr_i + CW'(k)) < CW'(BUF_BYTES))
          mem[AW'(wr_ptr_i + CW'(k))] <= wr_data_i[8*k +: 8];
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/txw_ctrl.sv
module txw_ctrl #(
  parameter int unsigned AW        = 11,
  parameter int unsigned CW        = 13,
  parameter int unsigned MIN_FRAME = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pad_en_i,
  input  logic          crc_ins_i,
  input  logic          rearm_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  input  logic          too_long_i,
  input  logic [CW-1:0] target_i,
  output logic          wr_first_o,
  output logic          wr_word_o,
  output logic [CW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [7:0]    out_data_o,
  output logic          out_sop_o,
  output logic          out_eop_o,
  output logic          done_o,
  output logic          err_o
);
  import txw_pkg::*;

  txw_state_e    state;
  logic [CW-1:0] wptr, target, idx, dlen, slen;
  logic          crc_lat;
  logic          accept, hs, last;
  logic [CW-1:0] next_ptr, cut_len;

  always_comb begin
    wr_ready_o  = (state != ST_SEND);
    accept      = wr_valid_i && wr_ready_o;
    wr_first_o  = accept && (state == ST_LEN) && !too_long_i;
    wr_word_o   = accept && (state == ST_FILL);
    wr_ptr_o    = wptr;
    next_ptr    = wptr + CW'(4);
    cut_len     = crc_lat ? target : target - CW'(CRC_BYTES);
    out_valid_o = (state == ST_SEND);
    rd_addr_o   = AW'(idx);
    out_data_o  = (idx < dlen) ? rd_data_i : 8'h00;
    out_sop_o   = out_valid_o && (idx == '0);
    last        = (idx == slen - CW'(1));
    out_eop_o   = out_valid_o && last;
    hs          = out_valid_o && out_ready_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_LEN;
      wptr    <= '0;
      target  <= '0;
      idx     <= '0;
      dlen    <= '0;
      slen    <= '0;
      crc_lat <= 1'b0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= hs && last;
      err_o  <= accept && (state == ST_LEN) && too_long_i;
      case (state)
        ST_LEN: begin
          if (accept && !too_long_i) begin
            target  <= target_i;
            crc_lat <= crc_ins_i;
            wptr    <= CW'(2);
            state   <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (rearm_i) begin
            state <= ST_LEN;
          end else if (accept) begin
            wptr <= next_ptr;
            if (next_ptr >= target) begin
              dlen  <= cut_len;
              slen  <= (pad_en_i && cut_len < CW'(MIN_FRAME)) ? CW'(MIN_FRAME) : cut_len;
              idx   <= '0;
              state <= ST_SEND;
            end
          end
        end
        default: begin
          if (hs) begin
            if (last) state <= ST_LEN;
            else      idx   <= idx + CW'(1);
          end
        end
      endcase
    end
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && out_eop_o) |=> (done_o && !out_valid_o));
  p_err_no_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (state == ST_LEN));
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> (idx < slen && dlen <= slen));
  p_pad_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_sop_o && slen != dlen) |-> (slen == CW'(MIN_FRAME)));
  p_ready_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> !wr_ready_o);
endmodule

// File: rtl/txw_framer.sv
module txw_framer #(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned MAX_LEN   = 2032,
  parameter int unsigned MIN_FRAME = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        crc_ins_i,
  input  logic        pad_en_i,
  input  logic        rearm_i,
  input  logic        wr_valid_i,
  output logic        wr_ready_o,
  input  logic [31:0] wr_data_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [7:0]  out_data_o,
  output logic        out_sop_o,
  output logic        out_eop_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int unsigned AW = $clog2(BUF_BYTES);
  localparam int unsigned CW = AW + 2;

  logic          too_long, wr_first, wr_word;
  logic [CW-1:0] target, wr_ptr;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;

  txw_len_calc #(.MAX_LEN(MAX_LEN), .CW(CW)) u_len (
    .len_i(wr_data_i[15:0]), .crc_ins_i(crc_ins_i),
    .too_long_o(too_long), .target_o(target)
  );

  txw_buf #(.BUF_BYTES(BUF_BYTES), .AW(AW), .CW(CW)) u_buf (
    .clk(clk), .wr_first_i(wr_first), .wr_word_i(wr_word), .wr_ptr_i(wr_ptr),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  txw_ctrl #(.AW(AW), .CW(CW), .MIN_FRAME(MIN_FRAME)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pad_en_i(pad_en_i), .crc_ins_i(crc_ins_i),
    .rearm_i(rearm_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .too_long_i(too_long), .target_i(target), .wr_first_o(wr_first),
    .wr_word_o(wr_word), .wr_ptr_o(wr_ptr), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
    .out_data_o(out_data_o), .out_sop_o(out_sop_o), .out_eop_o(out_eop_o),
    .done_o(done_o), .err_o(err_o)
  );
endmodule

// File: tb/txw_framer_tb.sv
module txw_framer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crc_ins = 1'b1, pad_en = 1'b0, rearm = 1'b0;
  logic wr_valid = 1'b0, wr_ready;
  logic [31:0] wr_data = '0;
  logic out_valid, out_ready = 1'b0, out_sop, out_eop, done, err;
  logic [7:0] out_data;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [9:0] sb [$];
  logic expect_done = 1'b0;

  always #5 clk = ~clk;

  txw_framer u_dut (
    .clk(clk), .rst_n(rst_n), .crc_ins_i(crc_ins), .pad_en_i(pad_en),
    .rearm_i(rearm), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_data_i(wr_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_sop_o(out_sop), .out_eop_o(out_eop),
    .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: choose ready first, then evaluate the handshake of the coming edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (expect_done) begin
        chk(done == 1'b1, "R9 done pulse", int'(done), 1);
        expect_done = 1'b0;
      end
      out_ready = ((cyc % 5) != 2) && ((cyc % 7) != 3);
      if (out_valid) chk(wr_ready == 1'b0, "R8 ready low while sending", int'(wr_ready), 0);
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R5 unexpected byte", int'(out_data), -1);
        end else begin
          logic [9:0] e;
          e = sb.pop_front();
          chk({out_sop, out_eop, out_data} == e, "R4/R6/R7 byte", int'({out_sop, out_eop, out_data}), int'(e));
        end
        if (out_eop) expect_done = 1'b1;
      end
    end
  end

  task automatic put_word(input logic [31:0] d);
    wr_data  = d;
    wr_valid = 1'b1;
    forever begin
      if (wr_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    wr_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((sb.size() != 0 || out_valid) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R5 all bytes sent", sb.size(), 0);
  endtask

  // send a frame of payload length len; R3 target, R5 cut, R6 pad
  task automatic send_frame(input int len, input bit ci, input bit pe, input int seed);
    int target, dlen, slen, wcnt;
    logic [7:0] fb [];
    crc_ins = ci;
    pad_en  = pe;
    target  = len + 14 + (ci ? 0 : 4);
    dlen    = ci ? target : target - 4;
    slen    = (pe && dlen < 60) ? 60 : dlen;
    wcnt    = (target - 2 + 3) / 4;
    fb = new[2 + 4 * wcnt];
    foreach (fb[i]) fb[i] = (i < target) ? 8'((i * 7 + seed) | 1) : 8'hEE;
    for (int i = 0; i < slen; i++) begin
      logic [7:0] b;
      b = (i < dlen) ? fb[i] : 8'h00;
      sb.push_back({(i == 0), (i == slen - 1), b});
    end
    put_word({fb[1], fb[0], 16'(len)});
    for (int w = 0; w < wcnt; w++)
      put_word({fb[2+4*w+3], fb[2+4*w+2], fb[2+4*w+1], fb[2+4*w]});
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_ready == 1'b1, "R1 ready after reset", int'(wr_ready), 1);
    chk(out_valid == 1'b0, "R1 no output after reset", int'(out_valid), 0);
    chk(done == 1'b0 && err == 1'b0, "R1 pulses idle", int'({done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    send_frame(50, 1'b1, 1'b0, 3);   // R3 target 64, R4 order
    send_frame(3, 1'b1, 1'b1, 9);    // R6 pad 17 -> 60
    send_frame(3, 1'b0, 1'b1, 5);    // R5 crc cut 21 -> 17, R6 pad
    send_frame(3, 1'b0, 1'b0, 11);   // R6 no pad when disabled
    send_frame(46, 1'b0, 1'b1, 2);   // R6 exactly 60, no pad
    send_frame(0, 1'b1, 1'b0, 4);    // R3 header-only frame

    // R2 oversize lengths
    put_word(32'h1234_07F1);
    chk(err == 1'b1, "R2 err after 2033", int'(err), 1);
    @(negedge clk);
    chk(err == 1'b0, "R2 err one cycle", int'(err), 0);
    put_word(32'hABCD_FFFF);
    chk(err == 1'b1, "R2 err after 65535", int'(err), 1);
    send_frame(10, 1'b1, 1'b0, 6);   // R2 next word is a length word

    send_frame(2032, 1'b1, 1'b0, 8); // R2 largest accepted length
    send_frame(2032, 1'b0, 1'b0, 1); // R5 largest with software crc

    // R10 rearm discards partial frame
    crc_ins = 1'b1;
    put_word(32'h5555_0020);
    put_word(32'h9999_9999);
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
    chk(out_valid == 1'b0, "R10 no output after rearm", int'(out_valid), 0);
    send_frame(20, 1'b1, 1'b0, 7);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule